// File: doc/BRIEF.md
# Two-Cluster Thread Memory Request Arbiter

This arbiter sits in front of a single bank queue of a shared memory controller and decides, every cycle, which of several threads may issue its pending request. It keeps a count, per thread, of the requests actually served during the current measurement window. At the end of each window it sorts the threads by that count. It then divides them into a light cluster and a heavy cluster, using a programmable fraction of the window's total traffic.

A requester in the light cluster always beats a requester in the heavy cluster. Inside the light cluster the thread that used the least bandwidth goes first, which favours throughput. Inside the heavy cluster the order is rotated at a fixed interval, so that no heavy thread is served first for long. Raising the threshold moves more threads into the light cluster, which trades fairness for throughput. The grant is one-hot and purely combinational from the request bits and the registered ranking. The served strobe tells the arbiter that the currently granted request has been taken.

Top module: `tcm_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set, and that bit belongs to a thread whose `req_i` bit is set. When `req_i` is zero, `grant_o` is zero.
- R2: A cycle with `served_i` high and a non-zero grant adds one to the granted thread's count for the current window. A cycle with `served_i` high and no grant changes no count.
- R3: A window is 1024 clock edges long, counted from the first edge after reset. The ranking is reloaded from the counts at the last edge of each window, and the counts are cleared on that same edge. A `served_i` pulse in that last cycle is not counted in either window.
- R4: At reload, threads are put in ascending order of count, and equal counts are ordered by the lower index first. A thread joins the heavy cluster exactly when 16 × (the sum of the counts of itself and every thread before it in that order) > `thresh_i` × (the sum of all counts). If the total is zero, every thread is light.
- R5: While any light thread requests, no heavy thread is granted.
- R6: Among requesting light threads, the grant goes to the one earliest in the sorted order.
- R7: A shuffle offset starts at 0 after reset and advances by one, wrapping modulo 8, every 128 clock edges. Among requesting heavy threads, the grant goes to the lowest key, where key = (sorted position + offset) mod 8.
- R8: From reset until the first reload, all threads are light and sorted by index, so the lowest-indexed requester wins.
- R9: `thresh_i` is read only at the reload edge. Its value at any other time has no effect on any grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | One pending-request bit per thread |
| served_i | input | 1 | The currently granted request was taken this cycle |
| thresh_i | input | 4 | Light-cluster share of total traffic, in sixteenths |
| grant_o | output | 8 | One-hot grant, zero when idle |

## Verification
The window reload and a served pulse can fall in the same cycle. The same is true of the reload and a shuffle step, since 1024 is a multiple of 128, so those two always coincide. The bench drives `served_i` high on every final window cycle, with one thread requesting. The count it would have added must then be absent from the next ranking. That is judged through the grants over the following window, which the bench compares with its own sort of the counts and its own offset. This also shows whether the offset stepped at that shared edge.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  // threshold resolution: fraction of total traffic in 1/2**THR_W steps
  localparam int unsigned THR_W = 4;
endpackage

// File: rtl/tcm_intensity.sv
module tcm_intensity #(
  parameter int unsigned N_THR   = 8,
  parameter int unsigned QUANTUM = 1024,
  localparam int unsigned CNT_W  = $clog2(QUANTUM + 1),
  localparam int unsigned QC_W   = $clog2(QUANTUM)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            served_i,
  input  logic [N_THR-1:0]                grant_i,
  output logic [N_THR-1:0][CNT_W-1:0]     cnt_o,
  output logic                            q_end_o
);
  logic [QC_W-1:0] q_cnt_q;

  assign q_end_o = (q_cnt_q == QC_W'(QUANTUM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_cnt_q <= '0;
    else if (q_end_o) q_cnt_q <= '0;
    else              q_cnt_q <= q_cnt_q + QC_W'(1);
  end

  for (genvar g = 0; g < N_THR; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_o[g] <= '0;
      else if (q_end_o)                cnt_o[g] <= '0;
      else if (served_i && grant_i[g]) cnt_o[g] <= cnt_o[g] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tcm_cluster.sv
module tcm_cluster
  import tcm_pkg::*;
#(
  parameter int unsigned N_THR   = 8,
  parameter int unsigned QUANTUM = 1024,
  localparam int unsigned CNT_W  = $clog2(QUANTUM + 1),
  localparam int unsigned IDX_W  = $clog2(N_THR),
  localparam int unsigned SUM_W  = CNT_W + IDX_W,
  localparam int unsigned PRD_W  = SUM_W + THR_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [THR_W-1:0]                thr_i,
  input  logic [N_THR-1:0][CNT_W-1:0]     cnt_i,
  output logic [N_THR-1:0]                heavy_o,
  output logic [N_THR-1:0][IDX_W-1:0]     pos_o
);
  logic [SUM_W-1:0]                total;
  logic [N_THR-1:0][SUM_W-1:0]     cum_c;
  logic [N_THR-1:0][IDX_W-1:0]     pos_c;
  logic [N_THR-1:0]                heavy_c;

  always_comb begin
    total   = '0;
    cum_c   = '0;
    pos_c   = '0;
    heavy_c = '0;
    for (int j = 0; j < N_THR; j++) total = total + SUM_W'(cnt_i[j]);
    for (int i = 0; i < N_THR; i++) begin
      for (int j = 0; j < N_THR; j++) begin
        // j sorts before i: smaller count, or equal count and lower index
        if (cnt_i[j] < cnt_i[i] || (cnt_i[j] == cnt_i[i] && j < i))
          pos_c[i] = pos_c[i] + IDX_W'(1);
        if (cnt_i[j] < cnt_i[i] || (cnt_i[j] == cnt_i[i] && j <= i))
          cum_c[i] = cum_c[i] + SUM_W'(cnt_i[j]);
      end
      heavy_c[i] = (PRD_W'(cum_c[i]) << THR_W) > (PRD_W'(thr_i) * PRD_W'(total));
    end
  end

  for (genvar g = 0; g < N_THR; g++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        heavy_o[g] <= 1'b0;
        pos_o[g]   <= IDX_W'(g);
      end else if (load_i) begin
        heavy_o[g] <= heavy_c[g];
        pos_o[g]   <= pos_c[g];
      end
    end
  end
endmodule

// File: rtl/tcm_shuffle.sv
module tcm_shuffle #(
  parameter int unsigned N_THR       = 8,
  parameter int unsigned SHUF_PERIOD = 128,
  localparam int unsigned IDX_W      = $clog2(N_THR),
  localparam int unsigned SC_W       = $clog2(SHUF_PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] off_o
);
  logic [SC_W-1:0] sc_q;
  logic            step;

  assign step = (sc_q == SC_W'(SHUF_PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q  <= '0;
      off_o <= '0;
    end else begin
      sc_q <= step ? '0 : sc_q + SC_W'(1);
      if (step) off_o <= (off_o == IDX_W'(N_THR - 1)) ? '0 : off_o + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tcm_pick.sv
module tcm_pick #(
  parameter int unsigned N_THR  = 8,
  localparam int unsigned IDX_W = $clog2(N_THR),
  localparam int unsigned KEY_W = IDX_W + 1
) (
  input  logic [N_THR-1:0]            req_i,
  input  logic [N_THR-1:0]            heavy_i,
  input  logic [N_THR-1:0][IDX_W-1:0] pos_i,
  input  logic [IDX_W-1:0]            off_i,
  output logic [N_THR-1:0]            grant_o
);
  logic [IDX_W:0]   rot;
  logic [IDX_W-1:0] prio;
  logic [KEY_W-1:0] key, best;
  logic [IDX_W-1:0] idx;
  logic             found;

  always_comb begin
    rot   = '0;
    prio  = '0;
    key   = '0;
    best  = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N_THR; i++) begin
      rot = {1'b0, pos_i[i]} + {1'b0, off_i};
      if (rot >= (IDX_W + 1)'(N_THR)) rot = rot - (IDX_W + 1)'(N_THR);
      prio = heavy_i[i] ? rot[IDX_W-1:0] : pos_i[i];
      // heavy bit on top: every light key is below every heavy key
      key = {heavy_i[i], prio};
      if (req_i[i] && (!found || key < best)) begin
        found = 1'b1;
        best  = key;
        idx   = IDX_W'(i);
      end
    end
    grant_o = found ? (N_THR'(1) << idx) : '0;
  end
endmodule

// File: rtl/tcm_arbiter.sv
module tcm_arbiter
  import tcm_pkg::*;
#(
  parameter int unsigned N_THR       = 8,
  parameter int unsigned QUANTUM     = 1024,
  parameter int unsigned SHUF_PERIOD = 128,
  localparam int unsigned CNT_W      = $clog2(QUANTUM + 1),
  localparam int unsigned IDX_W      = $clog2(N_THR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_THR-1:0] req_i,
  input  logic             served_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic [N_THR-1:0] grant_o
);
  logic [N_THR-1:0][CNT_W-1:0] cnt;
  logic                        q_end;
  logic [N_THR-1:0]            heavy_q;
  logic [N_THR-1:0][IDX_W-1:0] pos_q;
  logic [IDX_W-1:0]            shuf_off;

  tcm_intensity #(.N_THR(N_THR), .QUANTUM(QUANTUM)) u_intensity (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .served_i(served_i),
    .grant_i (grant_o),
    .cnt_o   (cnt),
    .q_end_o (q_end)
  );

  tcm_cluster #(.N_THR(N_THR), .QUANTUM(QUANTUM)) u_cluster (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (q_end),
    .thr_i  (thresh_i),
    .cnt_i  (cnt),
    .heavy_o(heavy_q),
    .pos_o  (pos_q)
  );

  tcm_shuffle #(.N_THR(N_THR), .SHUF_PERIOD(SHUF_PERIOD)) u_shuffle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .off_o (shuf_off)
  );

  tcm_pick #(.N_THR(N_THR)) u_pick (
    .req_i  (req_i),
    .heavy_i(heavy_q),
    .pos_i  (pos_q),
    .off_i  (shuf_off),
    .grant_o(grant_o)
  );
endmodule

// File: rtl/tcm_arbiter_chk.sv
module tcm_arbiter_chk #(
  parameter int unsigned N_THR   = 8,
  parameter int unsigned QUANTUM = 1024,
  localparam int unsigned CNT_W  = $clog2(QUANTUM + 1),
  localparam int unsigned IDX_W  = $clog2(N_THR)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_THR-1:0]            req_i,
  input logic                        served_i,
  input logic [N_THR-1:0]            grant_o,
  input logic                        q_end,
  input logic [N_THR-1:0]            heavy_q,
  input logic [N_THR-1:0][CNT_W-1:0] cnt,
  input logic [IDX_W-1:0]            shuf_off
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R1
  AST_GRANT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0); // R1
  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (grant_o == '0)); // R1
  AST_LIGHT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & heavy_q) != '0) |-> ((req_i & ~heavy_q) == '0)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_end && !served_i) |=> $stable(cnt)); // R2
  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_end |=> (cnt == '0)); // R3
  AST_CLUSTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_end |=> $stable(heavy_q)); // R9
  AST_SHUF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shuf_off) |->
      (shuf_off == (($past(shuf_off) == IDX_W'(N_THR - 1)) ? '0 : $past(shuf_off) + IDX_W'(1)))); // R7
endmodule

bind tcm_arbiter tcm_arbiter_chk #(.N_THR(N_THR), .QUANTUM(QUANTUM)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .served_i(served_i),
  .grant_o (grant_o),
  .q_end   (q_end),
  .heavy_q (heavy_q),
  .cnt     (cnt),
  .shuf_off(shuf_off)
);

// File: tb/tcm_arbiter_bench.sv
module tcm_arbiter_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0;
  logic       served_i = 1'b0;
  logic [3:0] thresh_i = '0;
  logic [7:0] grant_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  int m_cnt [8];
  bit m_heavy [8];
  int m_pos [8];
  int m_qc, m_sc, m_sh, m_loads;

  always #10 clk_i = ~clk_i;

  tcm_arbiter u_tcm_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
    .served_i(served_i), .thresh_i(thresh_i), .grant_o(grant_o)
  );

  function automatic logic [7:0] exp_grant(logic [7:0] r);
    int w = -1;
    int bk = 0;
    for (int i = 0; i < 8; i++)
      if (r[i] && !m_heavy[i] && (w < 0 || m_pos[i] < bk)) begin w = i; bk = m_pos[i]; end
    if (w < 0)
      for (int i = 0; i < 8; i++)
        if (r[i] && m_heavy[i] && (w < 0 || (m_pos[i] + m_sh) % 8 < bk)) begin
          w = i; bk = (m_pos[i] + m_sh) % 8;
        end
    return (w < 0) ? 8'h00 : (8'h01 << w);
  endfunction

  function automatic logic [7:0] heavy_mask();
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) m[i] = m_heavy[i];
    return m;
  endfunction

  task automatic recluster(int thr);
    int order [8];
    bit taken [8];
    int total = 0;
    int run = 0;
    for (int i = 0; i < 8; i++) begin taken[i] = 0; total += m_cnt[i]; end
    for (int k = 0; k < 8; k++) begin
      int s = -1;
      for (int i = 0; i < 8; i++)
        if (!taken[i] && (s < 0 || m_cnt[i] < m_cnt[s])) s = i;
      taken[s] = 1;
      order[k] = s;
    end
    for (int k = 0; k < 8; k++) begin
      run += m_cnt[order[k]];
      m_pos[order[k]] = k;
      m_heavy[order[k]] = (run * 16 > thr * total);
    end
  endtask

  task automatic model_edge();
    logic [7:0] g = exp_grant(req_i);
    if (m_qc == 1023) begin
      recluster(int'(thresh_i));
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
      m_loads++;
    end else if (served_i && g != 0) begin
      for (int i = 0; i < 8; i++) if (g[i]) m_cnt[i]++;
    end
    m_qc = (m_qc + 1) % 1024;
    if (m_sc == 127) begin m_sc = 0; m_sh = (m_sh + 1) % 8; end
    else m_sc++;
  endtask

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string tag_for(logic [7:0] r, logic [7:0] e);
    logic [7:0] hm = heavy_mask();
    if (r == 0) return "R1 idle";
    if (m_loads == 0) return "R8 reset order";
    if ((e & hm) != 0) return "R7 R3 heavy rotation";
    if ((r & hm) != 0) return "R5 R4 light over heavy";
    return "R6 R4 R2 R9 light order";
  endfunction

  // called at a negedge: drive, check, advance one edge, end at next negedge
  task automatic cyc(logic [7:0] r, logic s, logic [3:0] t);
    logic [7:0] e;
    req_i = r; served_i = s; thresh_i = t;
    #2;
    e = exp_grant(r);
    check(grant_o === e, tag_for(r, e), grant_o, e);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
  endtask

  task automatic run_quantum(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7,
                             logic [3:0] thr_mid, logic [3:0] thr_b);
    int cs [8];
    cs = '{c0, c1, c2, c3, c4, c5, c6, c7};
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < cs[i]; k++) cyc(8'h01 << i, 1'b1, thr_mid);
    for (int k = 0; k < 4; k++) cyc(8'h00, 1'b1, thr_mid); // R2: no grant, nothing counted
    while (m_qc != 1023) begin
      if (m_qc >= 800) cyc(heavy_mask() | (m_qc[0] ? 8'h00 : 8'h80), 1'b0, thr_mid);
      else cyc(m_qc[7:0] ^ 8'h5a, 1'b0, thr_mid);
    end
    cyc(8'h01, 1'b1, thr_b); // reload edge with a served pulse (R3)
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_heavy[i] = 0; m_pos[i] = i; end
    m_qc = 0; m_sc = 0; m_sh = 0; m_loads = 0;
    req_i = 8'hff;
    #5;
    check(grant_o === 8'h01, "R8 reset grant", grant_o, 8'h01);
    req_i = 8'h00;
    #1;
    check(grant_o === 8'h00, "R1 reset idle", grant_o, 8'h00);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    for (int p = 0; p < 256; p++) cyc(8'(p), 1'b0, 4'd3);          // R8 sweep
    run_quantum(12, 3, 0, 7, 25, 3, 40, 1, 4'd15, 4'd8);
    run_quantum(5, 5, 5, 5, 0, 0, 9, 9, 4'd1, 4'd0);
    run_quantum(30, 1, 2, 60, 4, 18, 0, 9, 4'd0, 4'd4);
    run_quantum(0, 0, 0, 0, 0, 0, 0, 0, 4'd9, 4'd12);              // R4 zero total
    run_quantum(8, 16, 24, 32, 40, 48, 56, 64, 4'd2, 4'd15);
    run_quantum(20, 20, 20, 20, 20, 20, 20, 20, 4'd7, 4'd12);
    run_quantum(2, 50, 3, 1, 70, 6, 11, 0, 4'd11, 4'd8);
    for (int p = 0; p < 512; p++) cyc(8'(p) ^ 8'hc3, 1'b0, 4'(p));  // R9 thr churn
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: grant=%b expected=%b", grant_o, 8'h00);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule